// File: doc/BRIEF.md
# Flash Read Page-Buffer Controller

This block sits between a 32-bit system bus and a slow non-volatile memory array. Each array read returns one 32-byte line. The controller keeps two read-page buffers and assigns each one to a fixed group of 32 KB erase blocks. The lower group is blocks 0 to 3 and the upper group is every block from 4 upward. A read whose line is already held by its group's buffer is answered in one clock, with no array traffic. Any other read fetches the line from the array, refills only that group's buffer, and answers after two clocks.

Reads may be byte, half-word or word wide. Data comes back right-justified and little-endian. The controller rejects the following with an error response, and none of them touches a buffer:

- burst requests
- reads outside the configured array size
- reads whose address does not suit their size

Writes are accepted and otherwise ignored, since in normal operation the array is read-only. The bus issues one request at a time and waits while `req_ready` is low.

Top module: `flash_page_ctrl`

## Requirements
- R1: After reset both buffers are empty, `rsp_valid` and `arr_rd_en` are low and `req_ready` is high, so the first read to each group is a miss.
- R2: A read whose line is not held by its group's buffer raises `arr_rd_en` in the request cycle, with `arr_line` equal to the address shifted right by 5. `req_ready` is low during the following cycle, and `rsp_valid` rises two clocks after the request.
- R3: A read whose line is held by its group's buffer gets `rsp_valid` one clock after the request, and no array read is issued.
- R4: Blocks are indexed by the address bits just above the 32 KB offset (bits 17:15 at the default size). Blocks below 4 use buffer 0 and the others use buffer 1. A refill replaces only the buffer of the addressed group, so a page held by the other group still hits.
- R5: `req_size` selects the width: 0 is a byte, 1 a half-word and 2 a word. The byte at the request address lands in bits 7:0 and higher addresses fill higher lanes. Unused upper bits are zero. The five low address bits select the byte within the line.
- R6: A read that is misaligned for its size gets `rsp_err` one clock after the request, with data zero and no array read. Misaligned means an odd half-word address, a word address that is not a multiple of 4, or size code 3. Such a read leaves both buffers unchanged.
- R7: A read at or beyond NUM_BLOCKS × 32 KB gets an error response in one clock, with no array read and no buffer change.
- R8: A request with `req_burst` set gets an error response in one clock, whether it is a read or a write.
- R9: A non-burst write gets a response in one clock, with `rsp_err` low and data zero. It causes no array read and changes no buffer: a held page still hits afterwards with its old data, and a page not held still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address within the module |
| req_size | input | 2 | Access width code |
| req_write | input | 1 | Request is a write |
| req_burst | input | 1 | Request is a burst |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 32 | Read data, right-justified |
| arr_rd_en | output | 1 | Array line read strobe |
| arr_line | output | ADDR_W-5 | Line address for the array |
| arr_rd_data | input | 256 | Line returned one clock after the strobe |

## Verification
On every cycle, the assertions check the following:

- The hit and miss latencies.
- `req_ready` stays low while a refill is in progress.
- At most one buffer is written in any cycle.
- Errors and writes leave the buffers' valid bits and tags unchanged.
- An array read only ever accompanies an accepted read.

Only the bench scenarios can show that the returned bytes are correct for each size and offset. The same holds for the choice of group at the block 3 to block 4 boundary, and for whether a page survives a refill of the other group or a write to it. The bench shows these by comparing against its own model of the two buffers.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int DATA_W     = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    CL_READ  = 2'd0,
    CL_WRITE = 2'd1,
    CL_ERR   = 2'd2
  } cls_e;

  // True when the offset does not suit the access width.
  function automatic logic size_misaligned(logic [OFF_W-1:0] off, logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return off[0];
      SZ_WORD: return off[1:0] != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  // Right-justified little-endian extraction from a line.
  function automatic logic [DATA_W-1:0] lane_pick(logic [LINE_W-1:0] line,
                                                  logic [OFF_W-1:0] off,
                                                  logic [1:0] sz);
    logic [LINE_W-1:0] sh;
    sh = line >> {off, 3'b000};
    case (sz)
      SZ_BYTE: return {24'b0, sh[7:0]};
      SZ_HALF: return {16'b0, sh[15:0]};
      default: return sh[31:0];
    endcase
  endfunction
endpackage

// File: rtl/fpb_decode.sv
module fpb_decode
  import fpb_pkg::*;
#(
  parameter int ADDR_W           = 20,
  parameter int NUM_BLOCKS       = 8,
  parameter int BLOCK_BYTES      = 32768,
  parameter int LOW_GROUP_BLOCKS = 4,
  localparam int TAG_W           = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_burst,
  output logic              grp,
  output logic [TAG_W-1:0]  tag,
  output logic [OFF_W-1:0]  off,
  output cls_e              cls
);
  localparam int BLK_SH      = $clog2(BLOCK_BYTES);
  localparam int ARRAY_BYTES = NUM_BLOCKS * BLOCK_BYTES;

  logic [ADDR_W-1:0] blk_idx;
  logic              in_range;

  assign blk_idx  = req_addr >> BLK_SH;
  assign grp      = blk_idx >= ADDR_W'(LOW_GROUP_BLOCKS);
  assign tag      = req_addr[ADDR_W-1:OFF_W];
  assign off      = req_addr[OFF_W-1:0];
  assign in_range = {1'b0, req_addr} < (ADDR_W+1)'(ARRAY_BYTES);

  always_comb begin
    if (req_burst)                          cls = CL_ERR;
    else if (req_write)                     cls = CL_WRITE;
    else if (!in_range)                     cls = CL_ERR;
    else if (size_misaligned(off, req_size)) cls = CL_ERR;
    else                                    cls = CL_READ;
  end
endmodule

// File: rtl/fpb_page_buf.sv
module fpb_page_buf
  import fpb_pkg::*;
#(
  parameter int TAG_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
    end else if (fill_we) begin
      valid_o <= 1'b1;
      tag_o   <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) line_o <= fill_line;
  end

  assign hit = valid_o && (tag_o == look_tag);
endmodule

// File: rtl/flash_page_ctrl.sv
module flash_page_ctrl
  import fpb_pkg::*;
#(
  parameter int ADDR_W           = 20,
  parameter int NUM_BLOCKS       = 8,
  parameter int BLOCK_BYTES      = 32768,
  parameter int LOW_GROUP_BLOCKS = 4,
  localparam int TAG_W           = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_burst,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_data,
  output logic              arr_rd_en,
  output logic [TAG_W-1:0]  arr_line,
  input  logic [LINE_W-1:0] arr_rd_data
);
  localparam int NUM_BUFS = 2;

  logic              d_grp;
  logic [TAG_W-1:0]  d_tag;
  logic [OFF_W-1:0]  d_off;
  cls_e              d_cls;

  fpb_decode #(
    .ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS),
    .BLOCK_BYTES(BLOCK_BYTES), .LOW_GROUP_BLOCKS(LOW_GROUP_BLOCKS)
  ) dec_i (
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_burst(req_burst), .grp(d_grp), .tag(d_tag), .off(d_off), .cls(d_cls)
  );

  // Named internal events (observed by the checker).
  logic                      acc, hit_acc, miss_acc, err_acc, fill_busy;
  logic [NUM_BUFS-1:0]       hit_vec, fill_we, buf_valid;
  logic [NUM_BUFS*TAG_W-1:0] buf_tags;
  logic [LINE_W-1:0]         buf_line [NUM_BUFS];

  logic              pend_grp;
  logic [TAG_W-1:0]  pend_tag;
  logic [OFF_W-1:0]  pend_off;
  logic [1:0]        pend_size;

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    logic [TAG_W-1:0] tag_q;
    assign fill_we[g] = fill_busy && (pend_grp == 1'(g));
    fpb_page_buf #(.TAG_W(TAG_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .fill_we(fill_we[g]), .fill_tag(pend_tag),
      .fill_line(arr_rd_data), .look_tag(d_tag), .hit(hit_vec[g]),
      .valid_o(buf_valid[g]), .tag_o(tag_q), .line_o(buf_line[g])
    );
    assign buf_tags[g*TAG_W +: TAG_W] = tag_q;
  end

  assign req_ready = !fill_busy;
  assign acc       = req_valid && req_ready;
  assign hit_acc   = acc && (d_cls == CL_READ) && hit_vec[d_grp];
  assign miss_acc  = acc && (d_cls == CL_READ) && !hit_vec[d_grp];
  assign err_acc   = acc && (d_cls == CL_ERR);
  assign arr_rd_en = miss_acc;
  assign arr_line  = d_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_busy <= 1'b0;
      pend_grp  <= 1'b0;
      pend_tag  <= '0;
      pend_off  <= '0;
      pend_size <= '0;
    end else begin
      fill_busy <= miss_acc;
      if (miss_acc) begin
        pend_grp  <= d_grp;
        pend_tag  <= d_tag;
        pend_off  <= d_off;
        pend_size <= req_size;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (acc && !miss_acc) || fill_busy;
      rsp_err   <= err_acc;
      if (fill_busy)    rsp_data <= lane_pick(arr_rd_data, pend_off, pend_size);
      else if (hit_acc) rsp_data <= lane_pick(buf_line[d_grp], d_off, req_size);
      else              rsp_data <= '0;
    end
  end
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int TAG_W    = 15,
  parameter int NUM_BUFS = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic                      req_burst,
  input logic                      rsp_valid,
  input logic                      rsp_err,
  input logic                      arr_rd_en,
  input logic                      hit_acc,
  input logic                      miss_acc,
  input logic                      err_acc,
  input logic                      fill_busy,
  input logic [NUM_BUFS-1:0]       fill_we,
  input logic [NUM_BUFS-1:0]       buf_valid,
  input logic [NUM_BUFS*TAG_W-1:0] buf_tags
);
  a_r3_hit_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> rsp_valid && !rsp_err);

  a_r2_miss_waits: assert property (@(posedge clk) disable iff (!rst_n)
    miss_acc |=> fill_busy && !rsp_valid);

  a_r2_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |=> rsp_valid && !rsp_err && !fill_busy);

  a_r2_ready_low_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !req_ready);

  a_r4_single_refill: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we));

  a_r9_read_only_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> req_valid && req_ready && !req_write && !req_burst);

  a_r6_err_keeps_bufs: assert property (@(posedge clk) disable iff (!rst_n)
    err_acc |=> rsp_valid && rsp_err && $stable(buf_valid) && $stable(buf_tags));

  a_r9_write_keeps_bufs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !req_burst)
      |=> rsp_valid && !rsp_err && $stable(buf_valid) && $stable(buf_tags));
endmodule

bind flash_page_ctrl fpb_checker #(.TAG_W(TAG_W), .NUM_BUFS(NUM_BUFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_burst(req_burst), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .arr_rd_en(arr_rd_en), .hit_acc(hit_acc),
  .miss_acc(miss_acc), .err_acc(err_acc), .fill_busy(fill_busy),
  .fill_we(fill_we), .buf_valid(buf_valid), .buf_tags(buf_tags)
);

// File: tb/flash_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_page_ctrl_tb_top;
  localparam int ADDR_W = 20;
  localparam int TAG_W  = ADDR_W - 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              req_write = 1'b0;
  logic              req_burst = 1'b0;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_data;
  logic              arr_rd_en;
  logic [TAG_W-1:0]  arr_line;
  logic [255:0]      arr_rd_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model of the two buffers.
  bit mvalid [2];
  int mtag   [2];

  always #2 clk = ~clk;

  flash_page_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_burst(req_burst), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .arr_rd_en(arr_rd_en), .arr_line(arr_line),
    .arr_rd_data(arr_rd_data)
  );

  function automatic logic [7:0] ref_byte(int a);
    return 8'(a * 7 + (a >> 5) * 29 + 90);
  endfunction

  // Registered array read port.
  always @(posedge clk) begin
    if (arr_rd_en) begin
      for (int k = 0; k < 32; k++)
        arr_rd_data[k*8 +: 8] <= ref_byte(int'(arr_line) * 32 + k);
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(int addr, int sz, bit wr, bit bu, string req);
    bit grp, err, ign, hit, miss;
    int ln;
    logic [31:0] exp;
    ln   = addr >> 5;
    grp  = ((addr >> 15) & 7) >= 4;
    err  = bu || (!wr && (addr >= 262144 || sz == 3 ||
                          (sz == 1 && addr % 2 != 0) || (sz == 2 && addr % 4 != 0)));
    ign  = !bu && wr;
    hit  = !err && !ign && mvalid[grp] && mtag[grp] == ln;
    miss = !err && !ign && !hit;
    exp  = '0;
    if (!err && !ign) begin
      exp[7:0] = ref_byte(addr);
      if (sz >= 1) exp[15:8] = ref_byte(addr + 1);
      if (sz == 2) begin
        exp[23:16] = ref_byte(addr + 2);
        exp[31:24] = ref_byte(addr + 3);
      end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, req, "idle rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, req, "idle req_ready", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_size = 2'(sz);
    req_write = wr;   req_burst = bu;
    #1;
    chk(arr_rd_en == miss, req, "arr_rd_en", 32'(arr_rd_en), 32'(miss));
    if (miss) chk(arr_line == TAG_W'(ln), req, "arr_line", 32'(arr_line), 32'(ln));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
    if (!miss) begin
      chk(rsp_valid == 1'b1, req, "one-clock rsp_valid", 32'(rsp_valid), 1);
      chk(rsp_err == err, req, "rsp_err", 32'(rsp_err), 32'(err));
      chk(rsp_data == exp, req, "rsp_data", rsp_data, exp);
    end else begin
      chk(rsp_valid == 1'b0, req, "miss early rsp", 32'(rsp_valid), 0);
      chk(req_ready == 1'b0, req, "ready during fill", 32'(req_ready), 0);
      @(negedge clk);
      chk(rsp_valid == 1'b1, req, "two-clock rsp_valid", 32'(rsp_valid), 1);
      chk(rsp_err == 1'b0, req, "miss rsp_err", 32'(rsp_err), 0);
      chk(rsp_data == exp, req, "miss rsp_data", rsp_data, exp);
      mvalid[grp] = 1'b1;
      mtag[grp]   = ln;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mvalid[0] = 0; mvalid[1] = 0; mtag[0] = 0; mtag[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0, "R1", "reset rsp_valid", 32'(rsp_valid), 0);
    chk(arr_rd_en == 0, "R1", "reset arr_rd_en", 32'(arr_rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "reset req_ready", 32'(req_ready), 1);

    access('h00040, 2, 0, 0, "R1");   // first read, group 0: miss (R2)
    access('h00041, 0, 0, 0, "R3");   // hit, byte
    access('h00042, 1, 0, 0, "R5");   // hit, half
    access('h0005F, 0, 0, 0, "R5");   // last byte of line
    access('h0005C, 2, 0, 0, "R5");   // last word of line
    access('h20000, 2, 0, 0, "R1");   // first read, group 1 (block 4)
    access('h00044, 2, 0, 0, "R4");   // group 0 page kept
    access('h1FFFC, 2, 0, 0, "R4");   // block 3 -> group 0 refill
    access('h20008, 1, 0, 0, "R4");   // group 1 page kept
    access('h00040, 2, 0, 0, "R2");   // replaced: miss again
    access('h3FFFC, 2, 0, 0, "R2");   // block 7 miss
    access('h3FFFE, 1, 0, 0, "R3");   // hit
    access('h00041, 1, 0, 0, "R6");   // odd half
    access('h00042, 2, 0, 0, "R6");   // word not multiple of 4
    access('h00040, 3, 0, 0, "R6");   // reserved size
    access('h01001, 1, 0, 0, "R6");   // new page, misaligned
    access('h00048, 2, 0, 0, "R6");   // group 0 still hits after errors
    access('h40000, 0, 0, 0, "R7");   // just past array
    access('hFFFFC, 2, 0, 0, "R7");
    access('h00040, 2, 0, 1, "R8");   // burst read of held page
    access('h00040, 2, 1, 1, "R8");   // burst write
    access('h3FFFC, 2, 1, 0, "R9");   // write to held page
    access('h3FFFC, 2, 0, 0, "R9");   // still hits with old data
    access('h02000, 2, 1, 0, "R9");   // write to page not held
    access('h02000, 2, 0, 0, "R9");   // still misses
    access('h02003, 0, 0, 0, "R5");

    done = 1'b1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule